// File: doc/BRIEF.md
# Memory-Segment Delay Line

This block holds back a data word for a fixed number of clock cycles, set when the design is elaborated. Each word sampled on an enabled clock edge reappears at the output once that many enabled edges have gone by. A clock enable stalls the whole line: while it is low nothing moves, and the output keeps its value.

The storage is not a chain of registers. It is built from small addressed memories, each sixteen words deep, and each memory is stepped by a four-bit down-counter. A delay of up to 64 cycles forms one section. That section is split as evenly as possible into at most four memory segments, with segment lengths that differ by no more than one. When all segments have the same length, one counter drives every address. When they do not, a second counter serves the longer segments. Longer delays chain full 64-cycle sections and then add one section for the rest. A delay of zero turns the block into a combinational pass-through.

Top module: `dly_line`

## Requirements
- R1: With DELAY greater than 0, a word sampled on an enabled edge is driven on `dout` right after the DELAY-th enabled edge, counting the sampling edge as the first. It stays there until the next enabled edge. This holds for DELAY values of 1 and 16.
- R2: WIDTH may take any value from 1 to 64, and `din` and `dout` always share that width. A 64-bit line with a delay of 50 returns every bit of every word after exactly 50 enabled edges.
- R3: While `en` is 0, the line does not advance. `dout` holds its value whatever `din` does, and stalled cycles do not count towards the delay.
- R4: With DELAY equal to 0, `dout` equals `din` in the same cycle, with no clock edge in between.
- R5: A clock edge with `rst_n` low drives `dout` to 0 and discards every word in flight. After reset, `dout` stays 0 until the first word sampled after reset has travelled the whole delay. Words presented while `rst_n` is low are not sampled.
- R6: A delay of 64 cycles or less is held in ceil(DELAY/16) segments of at most 16 words each. The segment lengths differ by at most one, and a second address counter is present only when they differ. The line gives the exact delay for 17 (segments of 9 and 8) and for 64 (four segments of 16).
- R7: A delay above 64 is built from floor(DELAY/64) full 64-cycle sections followed by one section holding DELAY mod 64 cycles, if that remainder is not zero. The line gives the exact delay for 65 and for 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears the stored words and the address counters |
| en | input | 1 | Clock enable; when low, the line stalls |
| din | input | WIDTH | Data word entering the line |
| dout | output | WIDTH | Data word leaving the line, DELAY enabled cycles later |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any enabled cycle, so that every address counter starts inside its segment length. They also assume that `en` and `din` are stable around each rising edge. The bench therefore starts with several reset cycles and changes every input only on the falling edge. Stalls are drawn at random and in long fixed runs, while `din` keeps changing, so the hold checks see inputs that could disturb the state. A second reset is applied in the middle of a stream to show that words in flight are lost.

// File: rtl/dly_pkg.sv
`timescale 1ns/1ps
// Package dly_pkg
// Shared constants and elaboration-time partitioning functions for the
// memory-segment delay line. Assumes all arguments are non-negative.
package dly_pkg;
    localparam int SEG_DEPTH = 16;               // words per memory segment
    localparam int ADDR_W    = $clog2(SEG_DEPTH);
    localparam int SEC_SEGS  = 4;                // segments per full section
    localparam int SEC_MAX   = SEG_DEPTH * SEC_SEGS;

    // Number of sections needed for a total delay.
    function automatic int num_sections(input int total);
        return (total + SEC_MAX - 1) / SEC_MAX;
    endfunction

    // Length of section j: full sections first, then the remainder.
    function automatic int section_len(input int total, input int j);
        if (j < total / SEC_MAX)
            return SEC_MAX;
        return total % SEC_MAX;
    endfunction

    // Number of segments that hold a section of the given length.
    function automatic int seg_count(input int len);
        return (len + SEG_DEPTH - 1) / SEG_DEPTH;
    endfunction

    // Shorter segment length of a section.
    function automatic int seg_base(input int len);
        return len / seg_count(len);
    endfunction

    // How many segments are one word longer than the base.
    function automatic int seg_long(input int len);
        return len % seg_count(len);
    endfunction
endpackage

// File: rtl/dly_addr_ctr.sv
`timescale 1ns/1ps
// Module dly_addr_ctr
// Down-counter producing the shared address for segments of length LEN.
// It counts LEN-1 down to 0, wraps, and holds when en is low.
// Assumes 1 <= LEN <= SEG_DEPTH.
module dly_addr_ctr
    import dly_pkg::*;
#(
    parameter int LEN = SEG_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(LEN - 1);

    // Step the address down on each enabled edge, wrapping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= TOP;
        else if (en)
            addr <= (addr == '0) ? TOP : addr - ADDR_W'(1);
    end

    // R6: the address never leaves the segment it serves.
    p_addr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= TOP);

    // R3: a stalled cycle leaves the address alone.
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(addr));
endmodule

// File: rtl/dly_seg_ram.sv
`timescale 1ns/1ps
// Module dly_seg_ram
// One 16-word storage segment. In an enabled cycle, the word at addr is
// read out and the incoming word is then written to the same address.
// The contents are cleared on reset, so the output reads zero until data
// arrives. Assumes the address comes from a counter of this segment's length.
module dly_seg_ram
    import dly_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  din,
    output logic [WIDTH-1:0]  dout
);
    logic [WIDTH-1:0] mem [SEG_DEPTH];

    // Clear the storage on reset; otherwise write on an enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEG_DEPTH; i++)
                mem[i] <= '0;
        end else if (en) begin
            mem[addr] <= din;
        end
    end

    // Read the word the next write will replace.
    assign dout = mem[addr];

    // R3: while stalled, the segment output does not change.
    p_seg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout));
endmodule

// File: rtl/dly_section.sv
`timescale 1ns/1ps
// Module dly_section
// A chain of up to four segments that together delay LEN cycles.
// The leading segments are one word longer when LEN does not divide
// evenly, and only then is a second counter built for them.
// Assumes 1 <= LEN <= SEC_MAX.
module dly_section
    import dly_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int LEN   = SEC_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NSEG  = seg_count(LEN);
    localparam int BASE  = seg_base(LEN);
    localparam int NLONG = seg_long(LEN);

    logic [ADDR_W-1:0] addr_short;
    logic [ADDR_W-1:0] addr_long;
    logic [WIDTH-1:0]  link [NSEG+1];

    // Address counter for the base-length segments.
    dly_addr_ctr #(.LEN(BASE)) u_ctr_short (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .addr  (addr_short)
    );

    // Second counter only when some segments are one word longer.
    if (NLONG > 0) begin : g_long_ctr
        dly_addr_ctr #(.LEN(BASE + 1)) u_ctr_long (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .addr  (addr_long)
        );
    end else begin : g_one_ctr
        assign addr_long = addr_short;
    end

    assign link[0] = din;

    // Cascade the segments; the first NLONG use the longer counter.
    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        logic [ADDR_W-1:0] seg_addr;
        if (i < NLONG) begin : g_l
            assign seg_addr = addr_long;
        end else begin : g_s
            assign seg_addr = addr_short;
        end
        dly_seg_ram #(.WIDTH(WIDTH)) u_seg (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .addr  (seg_addr),
            .din   (link[i]),
            .dout  (link[i+1])
        );
    end

    assign dout = link[NSEG];
endmodule

// File: rtl/dly_line.sv
`timescale 1ns/1ps
// Module dly_line
// Top of the delay line. DELAY = 0 is a wire. Otherwise the line is
// floor(DELAY/64) full sections plus one section for the remainder.
// Assumes 1 <= WIDTH <= 64 and DELAY >= 0.
module dly_line
    import dly_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DELAY = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NSEC = num_sections(DELAY);

    if (DELAY == 0) begin : g_wire
        // Zero delay: the output follows the input directly.
        assign dout = din;
    end else begin : g_chain
        logic [WIDTH-1:0] stage [NSEC+1];
        assign stage[0] = din;

        // Chain the sections, full-length ones first.
        for (genvar j = 0; j < NSEC; j++) begin : g_sec
            dly_section #(
                .WIDTH (WIDTH),
                .LEN   (section_len(DELAY, j))
            ) u_sec (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (en),
                .din   (stage[j]),
                .dout  (stage[j+1])
            );
        end

        assign dout = stage[NSEC];

        // R5: after a reset edge, the output reads zero.
        p_reset_clears_r5: assert property (@(posedge clk)
            !rst_n |=> dout == '0);
    end
endmodule

// File: tb/tb_dly_line.sv
`timescale 1ns/1ps
// Bench for dly_line: several instances with different delays share one
// stimulus stream and are compared against a queue of accepted words.
module tb_dly_line;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [63:0] din = '0;

    logic [7:0]  q0, q1, q16, q17, q64, q65, q100;
    logic [63:0] q50w;

    always #2.5 clk = ~clk;

    dly_line #(.WIDTH(8), .DELAY(100)) dut   (.clk(clk), .rst_n(rst_n), .en(en), .din(din[7:0]), .dout(q100));
    dly_line #(.WIDTH(8), .DELAY(0))   u_d0  (.clk(clk), .rst_n(rst_n), .en(en), .din(din[7:0]), .dout(q0));
    dly_line #(.WIDTH(8), .DELAY(1))   u_d1  (.clk(clk), .rst_n(rst_n), .en(en), .din(din[7:0]), .dout(q1));
    dly_line #(.WIDTH(8), .DELAY(16))  u_d16 (.clk(clk), .rst_n(rst_n), .en(en), .din(din[7:0]), .dout(q16));
    dly_line #(.WIDTH(8), .DELAY(17))  u_d17 (.clk(clk), .rst_n(rst_n), .en(en), .din(din[7:0]), .dout(q17));
    dly_line #(.WIDTH(8), .DELAY(64))  u_d64 (.clk(clk), .rst_n(rst_n), .en(en), .din(din[7:0]), .dout(q64));
    dly_line #(.WIDTH(8), .DELAY(65))  u_d65 (.clk(clk), .rst_n(rst_n), .en(en), .din(din[7:0]), .dout(q65));
    dly_line #(.WIDTH(64), .DELAY(50)) u_w64 (.clk(clk), .rst_n(rst_n), .en(en), .din(din),      .dout(q50w));

    // Reference: every word sampled since the last reset, in order.
    logic [63:0] hist [4096];
    int          nacc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic        last_en = 1'b0;
    logic        last_rst = 1'b0;
    string       force_tag = "";

    // Phase table: [31:16] cycle count, [1:0] enable mode
    // (0 always on, 1 stalled, 2 random about 70 percent, 3 alternating).
    localparam int PH_N = 8;
    localparam logic [31:0] PHASES [PH_N] = '{
        {16'd150, 16'd0}, {16'd20, 16'd1}, {16'd300, 16'd2}, {16'd80, 16'd3},
        {16'd200, 16'd0}, {16'd30, 16'd1}, {16'd200, 16'd2}, {16'd100, 16'd0}
    };

    function automatic logic [63:0] expect_for(input int d);
        if (nacc >= d)
            return hist[nacc - d];
        return 64'd0;
    endfunction

    task automatic chk(input string tag, input string nm,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
        end
    endtask

    function automatic string pick(input string dflt);
        if (force_tag != "") return force_tag;
        if (!last_rst) return "R5";
        if (!last_en) return "R3";
        return dflt;
    endfunction

    // Compare every clocked instance with the reference queue.
    task automatic check_all();
        chk(pick("R1"), "d1",   {56'd0, q1},   {56'd0, expect_for(1)   [7:0]});
        chk(pick("R1"), "d16",  {56'd0, q16},  {56'd0, expect_for(16)  [7:0]});
        chk(pick("R6"), "d17",  {56'd0, q17},  {56'd0, expect_for(17)  [7:0]});
        chk(pick("R6"), "d64",  {56'd0, q64},  {56'd0, expect_for(64)  [7:0]});
        chk(pick("R7"), "d65",  {56'd0, q65},  {56'd0, expect_for(65)  [7:0]});
        chk(pick("R7"), "d100", {56'd0, q100}, {56'd0, expect_for(100) [7:0]});
        chk(pick("R2"), "w64",  q50w,          expect_for(50));
    endtask

    // One cycle: check the state after the last edge, drive new inputs,
    // check the zero-delay path, then take the edge and update the model.
    task automatic cycle(input logic rst_v, input logic en_v, input logic [63:0] d);
        @(negedge clk);
        check_all();
        rst_n = rst_v;
        en    = en_v;
        din   = d;
        #1;
        chk("R4", "d0", {56'd0, q0}, {56'd0, d[7:0]});
        @(posedge clk);
        if (!rst_v)
            nacc = 0;
        else if (en_v) begin
            hist[nacc] = d;
            nacc++;
        end
        last_en  = en_v;
        last_rst = rst_v;
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state (R5): outputs read zero after reset edges.
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, rnd64());
        force_tag = "R5";
        cycle(1'b1, 1'b0, rnd64());
        force_tag = "";

        // Table-driven run across enable patterns.
        for (int p = 0; p < PH_N; p++) begin
            for (int c = 0; c < int'(PHASES[p][31:16]); c++) begin
                logic e;
                case (PHASES[p][1:0])
                    2'd0: e = 1'b1;
                    2'd1: e = 1'b0;
                    2'd2: e = (($urandom() % 10) < 7);
                    default: e = c[0];
                endcase
                cycle(1'b1, e, rnd64());
            end
        end

        // Directed stall (R3): a long stall with changing din holds every output.
        force_tag = "R3";
        for (int i = 0; i < 40; i++) cycle(1'b1, 1'b0, rnd64());
        force_tag = "";

        // Directed reset mid-stream (R5): words in flight are discarded.
        cycle(1'b0, 1'b1, rnd64());
        force_tag = "R5";
        for (int i = 0; i < 130; i++) cycle(1'b1, 1'b1, rnd64());
        force_tag = "";

        // Boundary delays again with sparse enables after the reset.
        for (int i = 0; i < 300; i++) cycle(1'b1, (($urandom() % 4) != 0), rnd64());
        @(negedge clk);
        check_all();
        finish_run();
    end
endmodule